// File: doc/BRIEF.md
# Shared-Coefficient Stereo FIR Engine

This block filters a stereo audio stream with one finite impulse response shared by the left and the right channel. A single multiply-accumulate datapath works through every tap of the left channel and then every tap of the right channel, all inside one sample period. Each channel keeps its recent input history in a circular block-RAM buffer. One coefficient store serves both channels. A sample strobe starts each run. After a fixed number of cycles the block delivers both filtered results together with a one-cycle valid pulse. Each result is rounded to nearest and clamped to the output range.

The coefficient store holds two banks. At any moment the datapath reads one of them and the write port fills the other. A commit pulse is remembered, and the banks trade roles at the next sample strobe. Software can therefore reload the response while audio keeps flowing, and no output ever combines taps from two different coefficient sets. Suppose a strobe arrives while products of the previous sample are still outstanding. That partial result is thrown away, an overrun pulse is raised, and the new sample is processed from scratch.

Top module: `sfir_stereo_engine`

## Requirements
- R1: After reset `res_l`, `res_r` are zero and `res_vld`, `overrun` are low until a sample has been processed.
- R2: For each accepted sample n, each channel output equals the scaled sum over k = 0..TAPS-1 of c[k]·x[n-k]. Here x[n] is that channel's newest sample and k = 0 is the newest tap. Both channels use the same active coefficient array c. Samples and coefficients are signed two's complement. The sum is scaled by 2^-FRAC (FRAC = 31 by default).
- R3: The scaling rounds to nearest, with exact halves going toward plus infinity. This is the same as adding 2^(FRAC-1) and then shifting right arithmetically by FRAC.
- R4: A scaled result below -2^(OUT_W-1) or above 2^(OUT_W-1)-1 is clamped to that limit (-8388608 and 8388607 for 24 bits).
- R5: `res_vld` is a one-cycle pulse exactly 2·TAPS+2 clock cycles after the edge that accepts the strobe. `res_l` and `res_r` take their new values in that same cycle.
- R6: A cycle with `cf_we` high stores `cf_data` at tap index `cf_addr` of the inactive bank. Such writes do not change any output until a commit has been followed by a strobe.
- R7: A `cf_commit` pulse is held pending, and the banks swap at the next strobe edge, which may be in the same cycle as the pulse. Every tap of that sample uses the new bank. Later writes go to the bank that was active before the swap.
- R8: A strobe that arrives within 2·TAPS+1 cycles of the previous strobe causes an overrun. `overrun` pulses for one cycle after that edge, and the unfinished result is dropped with no `res_vld`. The new sample then completes with R5 timing. The dropped sample still enters the delay line, and any pending commit still applies at that strobe.
- R9: A strobe exactly 2·TAPS+2 cycles after the previous one is accepted with no overrun, and the previous result is delivered in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe: a new stereo sample is present |
| smp_l | input | IN_W | Left input sample, signed |
| smp_r | input | IN_W | Right input sample, signed |
| cf_we | input | 1 | Coefficient write enable (inactive bank) |
| cf_addr | input | log2(TAPS) | Tap index of the coefficient write |
| cf_data | input | COEF_W | Coefficient value, signed |
| cf_commit | input | 1 | Request a bank swap at the next strobe |
| res_l | output | OUT_W | Filtered left result, signed |
| res_r | output | OUT_W | Filtered right result, signed |
| res_vld | output | 1 | One-cycle pulse: results updated |
| overrun | output | 1 | One-cycle pulse: a strobe cut a run short |

## Verification
The embedded properties assume three things about the inputs: the strobe and commit inputs are single-cycle pulses, reset is held for at least one edge, and coefficient addresses fit the tap range by width. The checks on bank stability and right-after-left ordering also assume that the only thing that can break a run is a strobe. The bench stays inside these assumptions. It drives strobes and commits for exactly one cycle, and it spaces strobes on purpose: either far enough apart to finish, or at chosen gaps of 1, TAPS, 2·TAPS+1 and 2·TAPS+2 cycles to cover the overrun boundary. It issues random coefficient writes and commits only while a run is in progress or between runs, and a reference model with its own two-bank view and history queue predicts every output.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   // tag that travels with each tap read towards the multiplier
   typedef struct packed {
      logic  vld;
      logic  first;
      logic  last;
      chan_e ch;
   } tap_tag_t;

endpackage

// File: rtl/sfir_sample_ram.sv
module sfir_sample_ram #(
   parameter int unsigned WIDTH = 24,
   parameter int unsigned DEPTH = 2048
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_addr,
   input  logic [WIDTH-1:0]         wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [WIDTH-1:0]         rd_data
);

   logic [WIDTH-1:0] mem [DEPTH];

   // one write port, one registered read port
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/sfir_coef_store.sv
module sfir_coef_store #(
   parameter int unsigned COEF_W = 32,
   parameter int unsigned TAPS   = 2048
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [$clog2(TAPS)-1:0] wr_addr,
   input  logic [COEF_W-1:0]       wr_data,
   input  logic                    commit,
   input  logic                    boundary,
   input  logic [$clog2(TAPS)-1:0] rd_addr,
   output logic [COEF_W-1:0]       rd_data,
   output logic                    bank
);

   localparam int unsigned AW = $clog2(TAPS);

   logic [COEF_W-1:0] mem [2*TAPS];
   logic              pend;

   // bank selector: a remembered commit takes effect only on a sample boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank <= 1'b0;
         pend <= 1'b0;
      end else if (boundary) begin
         bank <= bank ^ (pend | commit);
         pend <= 1'b0;
      end else if (commit) begin
         pend <= 1'b1;
      end
   end

   // writes land in the bank the datapath is not reading
   always_ff @(posedge clk) begin
      if (wr_en) mem[{~bank, wr_addr}] <= wr_data;
      rd_data <= mem[{bank, rd_addr}];
   end

   a_r7_swap_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (bank != $past(bank)) |-> $past(boundary))
      else $error("R7: coefficient bank changed away from a sample boundary");

   // keep the address width tied to the tap count
   if (AW < 1) begin : g_bad_aw
      $error("sfir_coef_store: TAPS must be at least 2");
   end

endmodule

// File: rtl/sfir_round_sat.sv
module sfir_round_sat #(
   parameter int unsigned ACC_W = 67,
   parameter int unsigned OUT_W = 24,
   parameter int unsigned FRAC  = 31
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic        [OUT_W-1:0] y
);

   localparam logic signed [ACC_W-1:0] HI = (ACC_W'(1) << (OUT_W - 1)) - ACC_W'(1);
   localparam logic signed [ACC_W-1:0] LO = ~HI;

   logic signed [ACC_W-1:0] scaled;

   // variant picked by the fraction width: plain pass or round-half-up shift
   if (FRAC == 0) begin : g_int
      assign scaled = acc;
   end else begin : g_rnd
      localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
      assign scaled = (acc + HALF) >>> FRAC;
   end

   always_comb begin
      if (scaled > HI)      y = HI[OUT_W-1:0];
      else if (scaled < LO) y = LO[OUT_W-1:0];
      else                  y = scaled[OUT_W-1:0];
   end

   if (OUT_W + FRAC >= ACC_W) begin : g_bad_w
      $error("sfir_round_sat: accumulator too narrow for OUT_W and FRAC");
   end

   // R4: clamping and rounding never flip the sign of the sum
   always_comb begin
      a_r4_sign_kept: assert ((acc[ACC_W-1] || !y[OUT_W-1]) &&
                              (!acc[ACC_W-1] || y[OUT_W-1] || y == '0))
         else $error("R4: scaled result sign differs from accumulator sign");
   end

endmodule

// File: rtl/sfir_stereo_engine.sv
module sfir_stereo_engine import sfir_pkg::*; #(
   parameter int unsigned TAPS   = 2048,
   parameter int unsigned IN_W   = 24,
   parameter int unsigned COEF_W = 32,
   parameter int unsigned OUT_W  = 24,
   parameter int unsigned FRAC   = 31
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_stb,
   input  logic [IN_W-1:0]         smp_l,
   input  logic [IN_W-1:0]         smp_r,
   input  logic                    cf_we,
   input  logic [$clog2(TAPS)-1:0] cf_addr,
   input  logic [COEF_W-1:0]       cf_data,
   input  logic                    cf_commit,
   output logic [OUT_W-1:0]        res_l,
   output logic [OUT_W-1:0]        res_r,
   output logic                    res_vld,
   output logic                    overrun
);

   localparam int unsigned AW     = $clog2(TAPS);
   localparam int unsigned PROD_W = IN_W + COEF_W;
   localparam int unsigned ACC_W  = PROD_W + AW;
   localparam logic [AW-1:0] LAST_TAP = AW'(TAPS - 1);

   // elaboration-time parameter checks
   if (TAPS < 2 || (TAPS & (TAPS - 1)) != 0) begin : g_bad_taps
      $error("sfir_stereo_engine: TAPS must be a power of two, at least 2");
   end
   if (OUT_W > IN_W + COEF_W) begin : g_bad_out
      $error("sfir_stereo_engine: OUT_W wider than the product");
   end

   // ---------------- sequencer ----------------
   logic           busy;
   chan_e          ch;
   logic [AW-1:0]  tap, wptr, base, rd_ptr;
   tap_tag_t       tag;
   logic           cut;

   assign rd_ptr = base - tap;
   assign cut    = smp_stb && (busy || tag.vld);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         ch      <= CH_LEFT;
         tap     <= '0;
         wptr    <= '0;
         base    <= '0;
         tag     <= '0;
         overrun <= 1'b0;
      end else begin
         overrun <= cut;
         if (smp_stb) begin
            busy    <= 1'b1;
            ch      <= CH_LEFT;
            tap     <= '0;
            base    <= wptr;
            wptr    <= wptr + 1'b1;
            tag.vld <= 1'b0;
         end else if (busy) begin
            tag.vld   <= 1'b1;
            tag.first <= (tap == '0);
            tag.last  <= (tap == LAST_TAP);
            tag.ch    <= ch;
            tap       <= tap + 1'b1;
            if (tap == LAST_TAP) begin
               if (ch == CH_RIGHT) busy <= 1'b0;
               else                ch   <= CH_RIGHT;
            end
         end else begin
            tag.vld <= 1'b0;
         end
      end
   end

   // ---------------- memories ----------------
   logic [IN_W-1:0]   wdat [2];
   logic [IN_W-1:0]   xrd  [2];
   logic [COEF_W-1:0] coef_rd;
   logic              bank;

   assign wdat[0] = smp_l;
   assign wdat[1] = smp_r;

   for (genvar g = 0; g < 2; g++) begin : g_line
      sfir_sample_ram #(
         .WIDTH (IN_W),
         .DEPTH (TAPS)
      ) i_ram (
         .clk     (clk),
         .wr_en   (smp_stb),
         .wr_addr (wptr),
         .wr_data (wdat[g]),
         .rd_addr (rd_ptr),
         .rd_data (xrd[g])
      );
   end

   sfir_coef_store #(
      .COEF_W (COEF_W),
      .TAPS   (TAPS)
   ) i_coef (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cf_we),
      .wr_addr  (cf_addr),
      .wr_data  (cf_data),
      .commit   (cf_commit),
      .boundary (smp_stb),
      .rd_addr  (tap),
      .rd_data  (coef_rd),
      .bank     (bank)
   );

   // ---------------- multiply-accumulate ----------------
   logic [IN_W-1:0]          x_sel;
   logic signed [PROD_W-1:0] xs, cs, prod;
   logic signed [ACC_W-1:0]  prod_ext, acc;
   logic                     d_vld;
   chan_e                    d_ch;

   assign x_sel    = (tag.ch == CH_RIGHT) ? xrd[1] : xrd[0];
   assign xs       = {{COEF_W{x_sel[IN_W-1]}}, x_sel};
   assign cs       = {{IN_W{coef_rd[COEF_W-1]}}, coef_rd};
   assign prod     = xs * cs;
   assign prod_ext = {{AW{prod[PROD_W-1]}}, prod};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         d_vld <= 1'b0;
         d_ch  <= CH_LEFT;
      end else begin
         if (tag.vld) acc <= tag.first ? prod_ext : acc + prod_ext;
         d_vld <= tag.vld && tag.last && !smp_stb;
         d_ch  <= tag.ch;
      end
   end

   // ---------------- scaling and output ----------------
   logic [OUT_W-1:0] sat, hold;

   sfir_round_sat #(
      .ACC_W (ACC_W),
      .OUT_W (OUT_W),
      .FRAC  (FRAC)
   ) i_rs (
      .acc (acc),
      .y   (sat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold    <= '0;
         res_l   <= '0;
         res_r   <= '0;
         res_vld <= 1'b0;
      end else begin
         res_vld <= d_vld && (d_ch == CH_RIGHT);
         if (d_vld && d_ch == CH_LEFT) hold <= sat;
         if (d_vld && d_ch == CH_RIGHT) begin
            res_l <= hold;
            res_r <= sat;
         end
      end
   end

   // ---------------- properties ----------------
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> !res_vld)
      else $error("R5: result valid held longer than one cycle");

   a_r5_done_after_right: assert property (@(posedge clk) disable iff (!rst_n)
      (tag.vld && tag.last && tag.ch == CH_RIGHT && !smp_stb) |=> ##1 res_vld)
      else $error("R5: last right tap not followed by a result");

   a_r8_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(overrun && res_vld))
      else $error("R8: result delivered for an overrun sample");

   a_r2_right_follows_left: assert property (@(posedge clk) disable iff (!rst_n)
      (tag.vld && tag.first && tag.ch == CH_RIGHT)
         |-> $past(tag.vld && tag.last && tag.ch == CH_LEFT))
      else $error("R2: right channel started before the left one finished");

   a_r7_bank_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !smp_stb) |=> $stable(bank))
      else $error("R7: coefficient bank moved during a run");

endmodule

// File: tb/test_sfir_stereo_engine.sv
`timescale 1ns/1ps
module test_sfir_stereo_engine;

   localparam int T  = 8;
   localparam int AW = 3;
   localparam int LAT = 2*T + 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          smp_stb;
   logic [23:0]   smp_l, smp_r;
   logic          cf_we;
   logic [AW-1:0] cf_addr;
   logic [31:0]   cf_data;
   logic          cf_commit;
   logic [23:0]   res_l, res_r;
   logic          res_vld, overrun;

   int checks = 0;
   int errors = 0;

   longint cb [2][T];
   bit     act = 1'b0;
   bit     pend = 1'b0;
   longint hl[$];
   longint hr[$];

   always #4 clk = ~clk;

   sfir_stereo_engine #(.TAPS(T)) i_sfir_stereo_engine (
      .clk, .rst_n, .smp_stb, .smp_l, .smp_r,
      .cf_we, .cf_addr, .cf_data, .cf_commit,
      .res_l, .res_r, .res_vld, .overrun
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint a, input longint e);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, a, e);
      end
   endtask

   function automatic longint fir_ref(input bit right);
      longint s = 0;
      for (int k = 0; k < T; k++) begin
         longint x;
         if (right) x = (k < hr.size()) ? hr[k] : 0;
         else       x = (k < hl.size()) ? hl[k] : 0;
         s += cb[act][k] * x;
      end
      return s;
   endfunction

   function automatic longint rsat(input longint a);
      longint q = (a + (64'sd1 <<< 30)) >>> 31;
      if (q > 8388607)  q = 8388607;
      if (q < -8388608) q = -8388608;
      return q;
   endfunction

   function automatic longint s24(input logic [23:0] v);
      return longint'($signed(v));
   endfunction

   task automatic model_strobe(input logic [23:0] l, input logic [23:0] r);
      if (pend) act = ~act;
      pend = 1'b0;
      hl.push_front(s24(l));
      hr.push_front(s24(r));
      if (hl.size() > T) hl.delete(T);
      if (hr.size() > T) hr.delete(T);
   endtask

   task automatic drive_write(input int a, input logic [31:0] d);
      cf_we   = 1'b1;
      cf_addr = AW'(a);
      cf_data = d;
      cb[~act][a] = longint'($signed(d));
   endtask

   task automatic commit_now();
      cf_commit = 1'b1;
      pend = 1'b1;
      @(negedge clk);
      cf_commit = 1'b0;
   endtask

   // kind 0 random full range, 1 one half at tap 0, 2 max everywhere, 3 small random
   task automatic load_set(input int kind);
      for (int a = 0; a < T; a++) begin
         logic [31:0] d;
         case (kind)
            0: d = $urandom;
            1: d = (a == 0) ? 32'h4000_0000 : 32'h0;
            2: d = 32'h7FFF_FFFF;
            default: d = 32'($signed($urandom) >>> 5);
         endcase
         drive_write(a, d);
         @(negedge clk);
      end
      cf_we = 1'b0;
   endtask

   // one sample; nwr random writes and an optional commit happen during the run
   task automatic send(input logic [23:0] l, input logic [23:0] r, input int nwr,
                       input bit cm, input bit chk_en, input string req);
      longint el, er;
      int c;
      int left = nwr;
      bit cmp = cm;
      smp_l = l; smp_r = r; smp_stb = 1'b1;
      model_strobe(l, r);
      el = rsat(fir_ref(1'b0));
      er = rsat(fir_ref(1'b1));
      @(negedge clk);
      smp_stb = 1'b0;
      if (chk_en) chk(overrun == 1'b0, "R8", "spurious overrun", overrun, 0);
      c = 0;
      forever begin
         cf_we = 1'b0; cf_commit = 1'b0;
         if (left > 0) begin
            drive_write(int'($urandom % T), $urandom);
            left--;
         end else if (cmp) begin
            cf_commit = 1'b1; pend = 1'b1; cmp = 1'b0;
         end
         @(negedge clk);
         c++;
         if (res_vld || c > 4*T + 20) break;
      end
      cf_we = 1'b0; cf_commit = 1'b0;
      if (chk_en) begin
         chk(c == LAT, "R5", "latency", c, LAT);
         chk(s24(res_l) == el, req, "left result", s24(res_l), el);
         chk(s24(res_r) == er, req, "right result", s24(res_r), er);
      end
      @(negedge clk);
      if (chk_en) chk(res_vld == 1'b0, "R5", "valid pulse width", res_vld, 0);
   endtask

   // two strobes g cycles apart (g <= 2T+1 overrun, g == 2T+2 tight but legal)
   task automatic two(input logic [23:0] l1, input logic [23:0] r1,
                      input logic [23:0] l2, input logic [23:0] r2, input int g);
      longint e1l, e1r, e2l, e2r;
      int c;
      bit seen = 1'b0;
      bit ovr_exp = (g <= 2*T + 1);
      smp_l = l1; smp_r = r1; smp_stb = 1'b1;
      model_strobe(l1, r1);
      e1l = rsat(fir_ref(1'b0));
      e1r = rsat(fir_ref(1'b1));
      @(negedge clk);
      smp_stb = 1'b0;
      c = 0;
      while (c < g - 1) begin
         @(negedge clk);
         c++;
         if (res_vld) seen = 1'b1;
      end
      smp_l = l2; smp_r = r2; smp_stb = 1'b1;
      model_strobe(l2, r2);
      e2l = rsat(fir_ref(1'b0));
      e2r = rsat(fir_ref(1'b1));
      @(negedge clk);
      smp_stb = 1'b0;
      chk(overrun == ovr_exp, ovr_exp ? "R8" : "R9", "overrun flag", overrun, ovr_exp);
      if (ovr_exp) begin
         chk(!seen && !res_vld, "R8", "dropped result delivered", seen | res_vld, 0);
      end else begin
         chk(res_vld == 1'b1, "R9", "first result at tight spacing", res_vld, 1);
         chk(s24(res_l) == e1l, "R9", "first left", s24(res_l), e1l);
         chk(s24(res_r) == e1r, "R9", "first right", s24(res_r), e1r);
      end
      c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!res_vld && c < 4*T + 20);
      chk(c == LAT, "R8", "latency after restart", c, LAT);
      chk(s24(res_l) == e2l, "R8", "second left", s24(res_l), e2l);
      chk(s24(res_r) == e2r, "R8", "second right", s24(res_r), e2r);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R5 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; smp_stb = 1'b0; smp_l = '0; smp_r = '0;
      cf_we = 1'b0; cf_addr = '0; cf_data = '0; cf_commit = 1'b0;
      for (int b = 0; b < 2; b++) for (int a = 0; a < T; a++) cb[b][a] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(res_vld == 1'b0, "R1", "valid after reset", res_vld, 0);
      chk(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);
      chk(res_l == '0 && res_r == '0, "R1", "results after reset", s24(res_l), 0);

      // prime: known set, flush the delay lines, then fill the other bank
      load_set(3);
      commit_now();
      for (int i = 0; i < T; i++) send(24'd0, 24'd0, 0, 1'b0, 1'b0, "R2");
      load_set(3);

      // R2 random samples, same coefficients for both channels
      for (int i = 0; i < 10; i++) send($urandom, $urandom, 0, 1'b0, 1'b1, "R2");
      send(24'd1000, 24'd1000, 0, 1'b0, 1'b1, "R2");

      // R6 writes during runs without commit leave outputs on the old set
      for (int i = 0; i < 4; i++) send($urandom, $urandom, 5, 1'b0, 1'b1, "R6");

      // R7 commit during a run applies to the next sample only
      send($urandom, $urandom, 3, 1'b1, 1'b1, "R7");
      send($urandom, $urandom, 0, 1'b0, 1'b1, "R7");
      send($urandom, $urandom, 0, 1'b0, 1'b1, "R7");

      // R3 rounding: half coefficient at tap 0
      load_set(1);
      commit_now();
      send(24'd1, -24'sd1, 0, 1'b0, 1'b1, "R3");
      send(24'd3, -24'sd3, 0, 1'b0, 1'b1, "R3");
      send(24'd0, 24'd5, 0, 1'b0, 1'b1, "R3");

      // R4 saturation both ways
      load_set(2);
      commit_now();
      for (int i = 0; i < 3; i++) send(24'h7FFFFF, 24'h800000, 0, 1'b0, 1'b1, "R4");
      for (int i = 0; i < 3; i++) send(24'h800000, 24'h7FFFFF, 0, 1'b0, 1'b1, "R4");

      // R8 overrun at several gaps, R9 tight spacing
      load_set(3);
      commit_now();
      two($urandom, $urandom, $urandom, $urandom, 1);
      two($urandom, $urandom, $urandom, $urandom, T);
      two($urandom, $urandom, $urandom, $urandom, 2*T + 1);
      two($urandom, $urandom, $urandom, $urandom, 2*T + 2);

      // mixed random traffic
      for (int i = 0; i < 20; i++) begin
         int nw = int'($urandom % 6);
         bit cm = ($urandom % 4) == 0;
         if (cm) load_set(($urandom % 2) == 0 ? 0 : 3);
         send($urandom, $urandom, nw, cm, 1'b1, "R2");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule